// File: doc/BRIEF.md
# Toggle-Based Pulse Synchronizer

This block moves single-cycle event strobes from one clock domain into a second clock domain whose clock has no fixed phase or frequency relation to the first. Sampling a short strobe directly with a two-flop synchronizer can miss it completely. Instead, each strobe in the sending domain inverts a held level. That level is slow-changing and safe to sample. It is carried through a two-flop synchronizer on the receiving clock. A change detector in the receiving domain compares the last synchronizer stage with a delayed copy of it and turns each level change back into a single strobe.

The user drives a one-cycle strobe on the source side. One destination-clock-cycle strobe appears on the destination side a few destination cycles later. Successive source strobes must be spaced far enough apart that at least three destination rising edges fall between them. Each domain has its own active-low asynchronous reset.

Top module: `pulse_xfer`

## Requirements
- R1: While either reset is low, every register of that domain is zero. With both domains reset and no source strobes afterwards, `dst_pulse` stays low.
- R2: A high `src_pulse` at a `src_clk` rising edge inverts the source-side level. A low `src_pulse` leaves the level unchanged.
- R3: The source level reaches the destination through exactly two `dst_clk` flip-flops in series. An output strobe is only ever caused by a change seen at the first of these flops.
- R4: Every output strobe is high for exactly one `dst_clk` cycle.
- R5: Latency is counted from the `src_clk` rising edge that captures the strobe. `dst_pulse` goes high after the second `dst_clk` rising edge following that edge, or after the third edge if the first sample resolves late.
- R6: Every source strobe separated from its neighbours by at least three `dst_clk` rising edges yields exactly one output strobe, for destination clocks both faster and slower than the source clock.
- R7: While `src_pulse` stays low, `dst_pulse` never goes high.
- R8: Under the spacing rule of R6, two output strobes are separated by at least two low `dst_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_pulse | input | 1 | One-cycle event strobe, source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_pulse | output | 1 | One-cycle event strobe, destination domain |

## Verification
Some properties are checked on every cycle by assertions: the one-cycle width of each output strobe, the minimum gap between output strobes, the hold and invert behaviour of the source level, and the requirement that every strobe be traceable to a change at the first synchronizer flop. Other properties can only be shown by the bench's scenarios. These are the exact count of delivered strobes against strobes sent, the latency in destination edges, and correct delivery when the destination clock is faster than, slower than, or close to the source clock. Silence after reset and during idle periods is also shown by the scenarios.

// File: rtl/pulse_xfer.sv
`timescale 1ns/100ps
module pulse_xfer (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);

  logic src_level;
  logic sync_a, sync_b, sync_c;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) src_level <= 1'b0;
    else            src_level <= src_level ^ src_pulse;
  end

  AST_SRC_HOLD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_pulse |=> $stable(src_level)); // R2
  AST_SRC_FLIP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_pulse |=> (src_level != $past(src_level))); // R2

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_c <= 1'b0;
    end else begin
      sync_a <= src_level;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  assign dst_pulse = sync_b ^ sync_c;

  AST_PULSE_CAUSE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |-> ($past(sync_a) != $past(sync_a, 2))); // R3
  AST_PULSE_WIDTH: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |=> !dst_pulse); // R4
  AST_PULSE_GAP: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |=> !dst_pulse ##1 !dst_pulse); // R8

endmodule

// File: tb/pulse_xfer_test.sv
`timescale 1ns/100ps
module pulse_xfer_test;

  logic src_clk, src_rst_n, src_pulse;
  logic dst_clk, dst_rst_n;
  logic dst_pulse;

  int  checks = 0;
  int  failures = 0;
  real dst_half = 6.5;

  int  dst_edges = 0;
  int  pulse_cnt = 0;
  int  last_detect = 0;
  int  wide_cnt = 0;
  bit  prev_high = 1'b0;

  pulse_xfer uut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_pulse(src_pulse),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_pulse(dst_pulse)
  );

  initial begin
    src_clk = 1'b0;
    forever #5 src_clk = ~src_clk;
  end

  initial begin
    dst_clk = 1'b0;
    #0.5;
    forever begin
      dst_clk = 1'b1;
      #(dst_half);
      dst_clk = 1'b0;
      #(dst_half);
    end
  end

  always @(posedge dst_clk) dst_edges <= dst_edges + 1;

  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_pulse) begin
        pulse_cnt   = pulse_cnt + 1;
        last_detect = dst_edges;
        if (prev_high) wide_cnt = wide_cnt + 1;
      end
      prev_high = dst_pulse;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_one(output int e0);
    @(negedge src_clk);
    src_pulse = 1'b1;
    @(posedge src_clk);
    e0 = dst_edges;
    @(negedge src_clk);
    src_pulse = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 12; i++) @(posedge dst_clk);
    @(negedge dst_clk);
    @(negedge dst_clk);
  endtask

  task automatic test_reset();
    src_pulse = 1'b0;
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    repeat (4) @(posedge src_clk);
    #1;
    check(dst_pulse == 1'b0, "R1", "output during reset", dst_pulse, 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    pulse_cnt = 0;
    wide_cnt  = 0;
    settle();
    check(pulse_cnt == 0, "R1", "pulses after reset release", pulse_cnt, 0);
  endtask

  task automatic test_idle();
    int base = pulse_cnt;
    repeat (60) @(posedge src_clk);
    settle();
    check(pulse_cnt == base, "R7", "pulses while input idle", pulse_cnt - base, 0);
  endtask

  task automatic test_single(input real half);
    int e0, base, wbase, lat;
    dst_half = half;
    settle();
    base  = pulse_cnt;
    wbase = wide_cnt;
    send_one(e0);
    settle();
    lat = last_detect - e0;
    check(pulse_cnt - base == 1, "R6", "single strobe count", pulse_cnt - base, 1);
    check(lat == 2 || lat == 3, "R5", "latency in dst edges", lat, 2);
    check(wide_cnt == wbase, "R4", "strobe wider than one cycle", wide_cnt - wbase, 0);
  endtask

  task automatic test_burst(input real half, input int n);
    int e0, base, wbase, gap;
    dst_half = half;
    settle();
    gap   = int'($ceil(6.0 * half / 10.0)) + 1;
    base  = pulse_cnt;
    wbase = wide_cnt;
    for (int i = 0; i < n; i++) begin
      send_one(e0);
      repeat (gap) @(posedge src_clk);
    end
    settle();
    check(pulse_cnt - base == n, "R6", "burst strobe count", pulse_cnt - base, n);
    check(wide_cnt == wbase, "R4", "burst strobe width", wide_cnt - wbase, 0);
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_idle();
    test_single(6.5);
    test_single(3.5);
    test_single(18.5);
    test_burst(6.5, 10);
    test_burst(3.5, 12);
    test_burst(18.5, 8);
    test_burst(5.5, 10);
    test_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule